// File: doc/BRIEF.md
# Triggered Circular Sample Capture Buffer

This block records one 10-bit sample per channel on every clock into a circular buffer. It keeps two such buffers, called banks, and only one of them records at a time. When a trigger is accepted, the recording bank is frozen around the trigger point and recording moves to the other bank. A drain engine then copies a fixed-length event record from the frozen bank into an output FIFO. The record starts with a header slot that holds a 16-bit event number, followed by a short window of samples from every channel. Once the record is in the FIFO, the bank is released for recording again.

Software or a bus bridge pops the FIFO one 16-bit word at a time. The FIFO has show-ahead output and an empty flag. The capture window starts a programmable number of samples before the trigger sample, so every window contains history from before the trigger. A trigger is dropped in two cases: no bank is left to freeze, or the FIFO cannot take a whole record. Each dropped trigger is counted.

Top module: `trig_capture_buf`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0 and lost_cnt_o is 0. The first accepted trigger carries event number 0.
- R2: On every clock, the recording bank stores samples_i (channel c in bits c*10+9 down to c*10) at a running pointer that wraps at the bank depth.
- R3: The window of an accepted trigger holds SLOTS=4 consecutive samples per channel. Its first sample is pre_i samples before the trigger sample. A pre_i below SLOTS-1 is treated as SLOTS-1, so the window then ends on the trigger sample.
- R4: A record is (SLOTS+1)*NUM_CH = 40 words. Header word 0 holds the event number and header words 1 to 7 are 0. After the header come the data slots in time order, and within each slot the channels run in ascending order. Each sample sits zero-extended in bits 9:0 of its word.
- R5: The event number is 16 bits wide and increments by one for each accepted trigger. A dropped trigger does not change it.
- R6: An accepted trigger freezes the recording bank and moves recording to the other bank. A frozen bank is released once its record has been pushed. When both banks are frozen, the older one is drained first.
- R7: full_o is 1 exactly while both banks are frozen. While full_o is 1, a trigger is dropped and nothing is recorded.
- R8: A trigger is dropped when the FIFO word count, plus the words still owed by frozen banks, plus 40 would exceed the FIFO depth of 1024. An empty FIFO therefore holds 25 records.
- R9: lost_cnt_o increments by one on each dropped trigger.
- R10: rd_data_o shows the oldest FIFO word. rd_en_i pops that word, and rd_en_i while empty_o is 1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| samples_i | input | 80 | One 10-bit sample per channel, channel 0 in the low bits |
| trig_i | input | 1 | Trigger request, one per high cycle |
| pre_i | input | 8 | Pre-trigger offset in samples |
| rd_en_i | input | 1 | Pop the FIFO head word |
| rd_data_o | output | 16 | FIFO head word |
| empty_o | output | 1 | FIFO holds no word |
| full_o | output | 1 | Both banks frozen |
| lost_cnt_o | output | 16 | Dropped-trigger count |

## Verification
The bench builds the block with its defaults: 8 channels, 256-deep banks, 4 slots and a 1024-word FIFO. With these values one record drains in about 40 cycles. Three triggers placed ten cycles apart therefore freeze both banks and then lose the third trigger. Twenty-six triggers fired with reading stopped cross the 25-record FIFO limit. The 8-bit offset reaches far back, up to 200 samples before the trigger, and also reaches the clamped low values.

// File: rtl/capbuf_pkg.sv
`timescale 1ns/1ps
package capbuf_pkg;
  typedef enum logic {DR_IDLE, DR_BUSY} drain_st_e;
endpackage

// File: rtl/capbuf_ring.sv
`timescale 1ns/1ps
module capbuf_ring #(
  parameter int NUM_CH = 8,
  parameter int SMP_W  = 10,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH),
  localparam int ROW_W = NUM_CH * SMP_W
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic             wbank_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [ROW_W-1:0] wdata_i,
  input  logic             rbank_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [ROW_W-1:0] rdata_o
);
  // one row holds every channel of one sample instant
  logic [ROW_W-1:0] mem_q [2*DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[{wbank_i, waddr_i}] <= wdata_i;
  end

  assign rdata_o = mem_q[{rbank_i, raddr_i}];
endmodule

// File: rtl/capbuf_fifo.sv
`timescale 1ns/1ps
module capbuf_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 1024,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  data_i,
  input  logic          pop_i,
  output logic [W-1:0]  data_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] cnt_q;
  logic          pop;

  assign empty_o = (cnt_q == '0);
  assign pop     = pop_i && !empty_o;
  assign data_o  = mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wptr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + 1'b1;
      if (pop)    rptr_q <= rptr_q + 1'b1;
      case ({push_i, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (int'(cnt_q) < DEPTH));

  assert_empty_pop_ignored_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/capbuf_ctrl.sv
`timescale 1ns/1ps
module capbuf_ctrl
  import capbuf_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int SMP_W      = 10,
  parameter int WORD_W     = 16,
  parameter int DEPTH      = 256,
  parameter int SLOTS      = 4,
  parameter int FIFO_DEPTH = 1024,
  parameter int EVN_W      = 16,
  localparam int AW        = $clog2(DEPTH),
  localparam int ROW_W     = NUM_CH * SMP_W,
  localparam int EV_WORDS  = (SLOTS + 1) * NUM_CH,
  localparam int WC_W      = $clog2(EV_WORDS),
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1,
  localparam int PEND_W    = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trig_i,
  input  logic [AW-1:0]     pre_i,
  input  logic [CNT_W-1:0]  fifo_cnt_i,
  input  logic [ROW_W-1:0]  row_i,
  output logic              we_o,
  output logic              wbank_o,
  output logic [AW-1:0]     waddr_o,
  output logic              rbank_o,
  output logic [AW-1:0]     raddr_o,
  output logic              push_o,
  output logic [WORD_W-1:0] push_data_o,
  output logic              full_o,
  output logic [15:0]       lost_cnt_o
);
  logic [AW-1:0]     wr_ptr_q;
  logic              act_q;
  logic [1:0]        frozen_q;
  logic [AW-1:0]     start_q [2];
  logic [EVN_W-1:0]  evn_q [2];
  logic [EVN_W-1:0]  evcnt_q;
  logic [15:0]       lost_q;
  drain_st_e         st_q;
  logic              dbank_q;
  logic [WC_W-1:0]   wcnt_q;
  logic [PEND_W-1:0] pend_q;

  logic [AW-1:0]   pre_eff;
  logic            room, accept, drop, last, hdr;
  logic [WC_W-1:0] data_idx, slot;
  logic [CH_W-1:0] ch;
  logic [SMP_W-1:0] sample;

  assign pre_eff  = (pre_i < AW'(SLOTS - 1)) ? AW'(SLOTS - 1) : pre_i;
  assign room     = (int'(fifo_cnt_i) + int'(pend_q) + EV_WORDS) <= FIFO_DEPTH;
  assign accept   = trig_i && !frozen_q[act_q] && room;
  assign drop     = trig_i && !accept;

  assign push_o   = (st_q == DR_BUSY);
  assign last     = (wcnt_q == WC_W'(EV_WORDS - 1));
  assign hdr      = (wcnt_q < WC_W'(NUM_CH));
  assign data_idx = wcnt_q - WC_W'(NUM_CH);
  assign slot     = data_idx >> CH_W;
  assign ch       = data_idx[CH_W-1:0];
  assign sample   = row_i[int'(ch)*SMP_W +: SMP_W];

  assign rbank_o  = dbank_q;
  assign raddr_o  = start_q[dbank_q] + AW'(slot);
  assign push_data_o = hdr ? ((wcnt_q == '0) ? WORD_W'(evn_q[dbank_q]) : '0)
                           : WORD_W'(sample);

  assign we_o       = !frozen_q[act_q];
  assign wbank_o    = act_q;
  assign waddr_o    = wr_ptr_q;
  assign full_o     = &frozen_q;
  assign lost_cnt_o = lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      act_q    <= 1'b0;
      frozen_q <= '0;
      start_q  <= '{default: '0};
      evn_q    <= '{default: '0};
      evcnt_q  <= '0;
      lost_q   <= '0;
      st_q     <= DR_IDLE;
      dbank_q  <= 1'b0;
      wcnt_q   <= '0;
      pend_q   <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_q + 1'b1;
      if (accept) begin
        frozen_q[act_q] <= 1'b1;
        start_q[act_q]  <= wr_ptr_q - pre_eff;
        evn_q[act_q]    <= evcnt_q;
        evcnt_q         <= evcnt_q + 1'b1;
        act_q           <= ~act_q;
      end
      if (drop) lost_q <= lost_q + 1'b1;
      pend_q <= pend_q + (accept ? PEND_W'(EV_WORDS) : '0) - (push_o ? PEND_W'(1) : '0);
      case (st_q)
        DR_IDLE: if (|frozen_q) begin
          // with both frozen the recording pointer sits on the older bank
          dbank_q <= frozen_q[act_q] ? act_q : ~act_q;
          wcnt_q  <= '0;
          st_q    <= DR_BUSY;
        end
        DR_BUSY: begin
          wcnt_q <= wcnt_q + 1'b1;
          if (last) begin
            frozen_q[dbank_q] <= 1'b0;
            st_q              <= DR_IDLE;
          end
        end
        default: st_q <= DR_IDLE;
      endcase
    end
  end

  assert_drop_when_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && full_o) |=> (lost_cnt_o == $past(lost_cnt_o) + 16'd1));

  assert_no_record_when_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o |-> !we_o);

  assert_evnum_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trig_i |=> $stable(evcnt_q));

  assert_drain_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> frozen_q[dbank_q]);

  assert_reserve_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(fifo_cnt_i) + int'(pend_q)) <= FIFO_DEPTH);
endmodule

// File: rtl/trig_capture_buf.sv
`timescale 1ns/1ps
module trig_capture_buf #(
  parameter int NUM_CH     = 8,
  parameter int SMP_W      = 10,
  parameter int WORD_W     = 16,
  parameter int DEPTH      = 256,
  parameter int SLOTS      = 4,
  parameter int FIFO_DEPTH = 1024,
  parameter int EVN_W      = 16,
  localparam int AW        = $clog2(DEPTH),
  localparam int ROW_W     = NUM_CH * SMP_W,
  localparam int CNT_W     = $clog2(FIFO_DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ROW_W-1:0]  samples_i,
  input  logic              trig_i,
  input  logic [AW-1:0]     pre_i,
  input  logic              rd_en_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [15:0]       lost_cnt_o
);
  logic             we, wbank, rbank, push;
  logic [AW-1:0]    waddr, raddr;
  logic [ROW_W-1:0] row;
  logic [WORD_W-1:0] push_data;
  logic [CNT_W-1:0] fifo_cnt;

  capbuf_ring #(.NUM_CH(NUM_CH), .SMP_W(SMP_W), .DEPTH(DEPTH)) ring_i (
    .clk_i(clk_i), .we_i(we), .wbank_i(wbank), .waddr_i(waddr), .wdata_i(samples_i),
    .rbank_i(rbank), .raddr_i(raddr), .rdata_o(row)
  );

  capbuf_ctrl #(
    .NUM_CH(NUM_CH), .SMP_W(SMP_W), .WORD_W(WORD_W), .DEPTH(DEPTH),
    .SLOTS(SLOTS), .FIFO_DEPTH(FIFO_DEPTH), .EVN_W(EVN_W)
  ) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .pre_i(pre_i),
    .fifo_cnt_i(fifo_cnt), .row_i(row), .we_o(we), .wbank_o(wbank), .waddr_o(waddr),
    .rbank_o(rbank), .raddr_o(raddr), .push_o(push), .push_data_o(push_data),
    .full_o(full_o), .lost_cnt_o(lost_cnt_o)
  );

  capbuf_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) fifo_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .push_i(push), .data_i(push_data),
    .pop_i(rd_en_i), .data_o(rd_data_o), .empty_o(empty_o), .count_o(fifo_cnt)
  );
endmodule

// File: tb/trig_capture_buf_tb_top.sv
`timescale 1ns/1ps
module trig_capture_buf_tb_top;
  localparam int NUM_CH = 8;
  localparam int SMP_W  = 10;
  localparam int SLOTS  = 4;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [NUM_CH*SMP_W-1:0] samples_i = '0;
  logic        trig_i = 1'b0;
  logic [7:0]  pre_i = '0;
  logic        rd_en_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        empty_o, full_o;
  logic [15:0] lost_cnt_o;

  int  n_tests = 0, n_fail = 0;
  int  ecount = 0;
  int  ev_model = 0, lost_model = 0;
  bit  rd_on = 1'b1, force_rd = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  trig_capture_buf dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .samples_i(samples_i), .trig_i(trig_i), .pre_i(pre_i),
    .rd_en_i(rd_en_i), .rd_data_o(rd_data_o), .empty_o(empty_o), .full_o(full_o),
    .lost_cnt_o(lost_cnt_o)
  );

  function automatic logic [9:0] smp(int n, int c);
    return 10'((n * 13 + c * 71 + (n >> 3) * 5) & 32'h3FF);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_ni) ecount <= ecount + 1;

  // R2: drive the sample for the coming edge from its edge index
  always @(negedge clk) begin
    for (int c = 0; c < NUM_CH; c++) samples_i[c*SMP_W +: SMP_W] <= smp(ecount, c);
  end

  // monitor: pop and compare
  always @(negedge clk) begin
    if (rst_ni && rd_on && !empty_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10_unexpected_word", int'(rd_data_o), -1);
      end else begin
        check(rd_data_o == exp_q[0], tag_q[0], int'(rd_data_o), int'(exp_q[0]));
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
      rd_en_i <= 1'b1;
    end else begin
      rd_en_i <= force_rd;
    end
  end

  // driver: fire one trigger and queue its expected record
  task automatic fire(int pre, bit acc);
    int t, pe;
    @(negedge clk);
    trig_i = 1'b1;
    pre_i  = 8'(pre);
    t  = ecount;
    pe = (pre < SLOTS - 1) ? SLOTS - 1 : pre;
    if (acc) begin
      exp_q.push_back(16'(ev_model)); tag_q.push_back("R5_header_evnum");
      for (int k = 1; k < NUM_CH; k++) begin
        exp_q.push_back(16'h0); tag_q.push_back("R4_header_pad");
      end
      for (int s = 0; s < SLOTS; s++)
        for (int c = 0; c < NUM_CH; c++) begin
          exp_q.push_back({6'h0, smp(t - pe + s, c)}); tag_q.push_back("R3_window_R4_order");
        end
      ev_model++;
    end else begin
      lost_model++;
    end
    @(negedge clk);
    trig_i = 1'b0;
  endtask

  task automatic drain_wait();
    for (int i = 0; i < 3000 && (exp_q.size() != 0 || !empty_o); i++) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(empty_o == 1'b1, "R1_empty", int'(empty_o), 1);
    check(full_o == 1'b0, "R1_full", int'(full_o), 0);
    check(lost_cnt_o == 16'd0, "R1_lost", int'(lost_cnt_o), 0);
    repeat (300) @(negedge clk);

    // R10: pops on an empty FIFO leave it empty and do not disturb later data
    force_rd = 1'b1;
    repeat (5) @(negedge clk);
    force_rd = 1'b0;
    @(negedge clk);
    check(empty_o == 1'b1, "R10_empty_pop", int'(empty_o), 1);

    fire(5, 1'b1);             // R1 first event number 0, R3 mid offset
    repeat (100) @(negedge clk);
    fire(0, 1'b1);             // R3 clamp
    repeat (300) @(negedge clk);
    fire(200, 1'b1);           // R3 deep history, R2 wrap
    drain_wait();
    check(exp_q.size() == 0, "R4_record_length", exp_q.size(), 0);

    // R6/R7: three triggers ten cycles apart
    repeat (300) @(negedge clk);
    fire(5, 1'b1);
    repeat (8) @(negedge clk);
    fire(4, 1'b1);
    check(full_o == 1'b1, "R7_full_set", int'(full_o), 1);
    repeat (8) @(negedge clk);
    fire(3, 1'b0);
    check(int'(lost_cnt_o) == lost_model, "R9_lost_full", int'(lost_cnt_o), lost_model);
    check(full_o == 1'b1, "R7_full_hold", int'(full_o), 1);
    repeat (30) @(negedge clk);
    check(full_o == 1'b0, "R6_release", int'(full_o), 0);
    drain_wait();
    check(exp_q.size() == 0, "R6_order_drained", exp_q.size(), 0);

    // R8: FIFO room with reading stopped
    repeat (100) @(negedge clk);
    rd_on = 1'b0;
    for (int i = 0; i < 26; i++) begin
      fire(10, i < 25);
      repeat (58) @(negedge clk);
    end
    check(int'(lost_cnt_o) == lost_model, "R8_room_drop", int'(lost_cnt_o), lost_model);
    check(empty_o == 1'b0, "R8_fifo_filled", int'(empty_o), 0);
    check(full_o == 1'b0, "R7_banks_free", int'(full_o), 0);
    rd_on = 1'b1;
    drain_wait();
    check(exp_q.size() == 0, "R8_all_records", exp_q.size(), 0);
    check(empty_o == 1'b1, "R10_empty_end", int'(empty_o), 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule